// File: doc/BRIEF.md
# Conversion Result Register Pair with Read Lock

This block keeps the most recent 10-bit value from an analog converter and offers it to a processor bus as two 8-bit registers: a low byte and a high byte. A single alignment control sets where the 10 bits sit across the pair. In right placement the value fills the low byte and the bottom of the high byte. In left placement the top eight bits fill the high byte, so software that needs only 8 bits of precision reads just that one register.

A full 10-bit read takes two bus reads, and a conversion could finish between them. To keep the two bytes from the same conversion, a read of the low byte freezes the stored value until the high byte is read. A conversion that finishes while the value is frozen is thrown away. Its completion flag still pulses, so the interrupt logic counts every conversion, including the ones that were lost.

The converter is outside this block. Results arrive as a one-cycle strobe together with a 10-bit value.

Top module: `adc_rdlock`

## Requirements
- R1: While reset is asserted, and after it is released, the stored value is zero, the lock is clear, `rd_data` is 0 and `done_flag` is 0.
- R2: With `align_left` = 0, a low-byte read returns value bits 7..0. A high-byte read returns bits 9..8 in positions 1..0, with bits 7..2 reading as 0.
- R3: With `align_left` = 1, a high-byte read returns value bits 9..2. A low-byte read returns bits 1..0 in positions 7..6, with bits 5..0 reading as 0.
- R4: A low-byte read sets the lock. While the lock is set, a completed conversion changes neither byte, and the next reads return the value from before the lock.
- R5: A high-byte read clears the lock. A conversion that completes after that read is stored and is returned by later reads.
- R6: A conversion that completes in the same cycle as a low-byte read is dropped. That read, and the high-byte read after it, return the older value.
- R7: `done_flag` is high for exactly one cycle, in the cycle after each `conv_done` pulse, whether the result was stored or dropped.
- R8: A change of `align_left` alters the byte layout of the next read of the stored value, with no new conversion needed.
- R9: `rd_data` takes the selected byte in the cycle after a read strobe and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_value | input | 10 | Result that goes with `conv_done` |
| align_left | input | 1 | 0 = right placement, 1 = left placement |
| rd_lo | input | 1 | Read strobe for the low byte (sets the lock) |
| rd_hi | input | 1 | Read strobe for the high byte (clears the lock); takes priority over `rd_lo` for the lock if both are high |
| rd_data | output | 8 | Registered byte from the most recent read |
| done_flag | output | 1 | Completion pulse, one cycle after `conv_done` |

## Verification
A lock bit stuck set shows up at the first conversion after a high-byte read: the next pair of reads returns the old value instead of the new one. A lock bit that never sets lets a new value through between the two reads, so the high byte no longer matches the low byte. Faults in placement or padding appear as wrong bits in `rd_data` one cycle after the read strobe, and a flag that ignores dropped conversions misses its pulse one cycle after `conv_done`. The bench predicts every byte from its own model of the stored value and the lock, and checks it in that next cycle.

// File: rtl/adc_rdlock_pkg.sv
package adc_rdlock_pkg;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_LO   = 2'b01,
    SEL_HI   = 2'b10
  } rd_sel_e;

endpackage

// File: rtl/adc_rdlock_store.sv
module adc_rdlock_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_value,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [RES_W-1:0] value_q,
  output logic             lock_q,
  output logic             cap_en,
  output logic             drop_evt
);

  logic block;
  logic lock_d;

  // A low read in the same cycle as a conversion already blocks it.
  assign block    = lock_q | rd_lo;
  assign cap_en   = conv_done & ~block;
  assign drop_evt = conv_done & block;

  always_comb begin
    lock_d = lock_q;
    if (rd_lo) lock_d = 1'b1;
    if (rd_hi) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      if (cap_en) value_q <= conv_value;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (lock_q == 1'b0 && value_q == '0));

  a_r4_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> lock_q);

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(value_q));

  a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !lock_q);

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !lock_q && !rd_lo) |=> (value_q == $past(conv_value)));

  a_r6_same_cycle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && rd_lo) |=> $stable(value_q));

endmodule

// File: rtl/adc_rdlock_format.sv
module adc_rdlock_format #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  value,
  input  logic              align_left,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  import adc_rdlock_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - RES_W;

  function automatic logic [WORD_W-1:0] place_word(
    input logic [RES_W-1:0] v,
    input align_e           mode
  );
    if (mode == ALIGN_LEFT) place_word = {v, {PAD_W{1'b0}}};
    else                    place_word = {{PAD_W{1'b0}}, v};
  endfunction

  logic [WORD_W-1:0] word;

  generate
    if (RES_W <= BYTE_W || RES_W >= WORD_W) begin : g_bad_width
      initial $display("adc_rdlock_format: RES_W must lie between BYTE_W and 2*BYTE_W");
    end
  endgenerate

  assign word    = place_word(value, align_e'(align_left));
  assign lo_byte = word[BYTE_W-1:0];
  assign hi_byte = word[WORD_W-1:BYTE_W];

endmodule

// File: rtl/adc_rdlock_port.sv
module adc_rdlock_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic              conv_done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done_flag
);
  import adc_rdlock_pkg::*;

  rd_sel_e sel;

  always_comb begin
    if (rd_lo)      sel = SEL_LO;
    else if (rd_hi) sel = SEL_HI;
    else            sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      done_flag <= 1'b0;
    end else begin
      done_flag <= conv_done;
      case (sel)
        SEL_LO:  rd_data <= lo_byte;
        SEL_HI:  rd_data <= hi_byte;
        default: rd_data <= rd_data;
      endcase
    end
  end

  a_r7_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flag);

  a_r7_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !done_flag);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_lo || rd_hi) |=> $stable(rd_data));

endmodule

// File: rtl/adc_rdlock.sv
module adc_rdlock #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              align_left,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done_flag
);

  localparam int TOPPAD = 2 * BYTE_W - RES_W;

  logic [RES_W-1:0]  value_q;
  logic              lock_q;
  logic              cap_en;
  logic              drop_evt;
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;

  adc_rdlock_store #(.RES_W(RES_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .value_q    (value_q),
    .lock_q     (lock_q),
    .cap_en     (cap_en),
    .drop_evt   (drop_evt)
  );

  adc_rdlock_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_format (
    .value      (value_q),
    .align_left (align_left),
    .lo_byte    (lo_byte),
    .hi_byte    (hi_byte)
  );

  adc_rdlock_port #(.BYTE_W(BYTE_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .lo_byte    (lo_byte),
    .hi_byte    (hi_byte),
    .conv_done  (conv_done),
    .rd_data    (rd_data),
    .done_flag  (done_flag)
  );

  // R2: right placement leaves the upper high-byte bits at zero.
  a_r2_hi_padding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo && !align_left) |=> (rd_data[BYTE_W-1:RES_W-BYTE_W] == '0));

  // R3: left placement leaves the lower low-byte bits at zero.
  a_r3_lo_padding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && align_left) |=> (rd_data[TOPPAD-1:0] == '0));

  // R4: no capture while the lock is held.
  a_r4_no_capture_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !cap_en);

endmodule

// File: tb/adc_rdlock_test.sv
module adc_rdlock_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_value = '0;
  logic       align_left = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       done_flag;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  logic [9:0] m_val = '0;
  logic       m_lock = 1'b0;
  logic       issued = 1'b0;
  logic       wd_hit = 1'b0;

  always #10 clk = ~clk;

  adc_rdlock uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .align_left (align_left),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .rd_data    (rd_data),
    .done_flag  (done_flag)
  );

  function automatic logic [7:0] want_lo(input logic [9:0] v, input logic left);
    if (left) return {v[1:0], 6'd0};
    return v[7:0];
  endfunction

  function automatic logic [7:0] want_hi(input logic [9:0] v, input logic left);
    if (left) return v[9:2];
    return {6'd0, v[9:8]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) issued <= rd_lo | rd_hi;

  // Monitor: compare each registered read against the scoreboard.
  always @(negedge clk) begin
    if (issued) begin
      if (sbq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 actual=%h expected=none (no scoreboard entry)", rd_data);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic conv(input logic [9:0] v, input string tag);
    @(negedge clk);
    conv_done  = 1'b1;
    conv_value = v;
    if (!m_lock) m_val = v;
    @(negedge clk);
    conv_done = 1'b0;
    check(tag, {7'd0, done_flag}, 8'd1);
    @(negedge clk);
    check(tag, {7'd0, done_flag}, 8'd0);
  endtask

  task automatic rd(input logic hi, input string tag);
    item_t it;
    @(negedge clk);
    it.tag = tag;
    it.exp = hi ? want_hi(m_val, align_left) : want_lo(m_val, align_left);
    sbq.push_back(it);
    rd_hi = hi;
    rd_lo = !hi;
    m_lock = !hi;
    @(negedge clk);
    rd_hi = 1'b0;
    rd_lo = 1'b0;
  endtask

  task automatic rd_lo_with_conv(input logic [9:0] v, input string tag);
    item_t it;
    @(negedge clk);
    it.tag = tag;
    it.exp = want_lo(m_val, align_left);
    sbq.push_back(it);
    rd_lo = 1'b1;
    conv_done = 1'b1;
    conv_value = v;
    m_lock = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    conv_done = 1'b0;
    check({tag, " flag"}, {7'd0, done_flag}, 8'd1);
  endtask

  initial begin
    #1000000;
    wd_hit = 1'b1;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 8'h00);
    check("R1 flag in reset", {7'd0, done_flag}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 8'h00);
    rd(1'b0, "R1 low zero");
    rd(1'b1, "R1 high zero");

    conv(10'h2D6, "R7 flag stored");
    rd(1'b0, "R2 low right");
    rd(1'b1, "R2 high right");
    conv(10'h3FF, "R7 flag stored ff");
    rd(1'b0, "R2 low all ones");
    rd(1'b1, "R2 high all ones");

    align_left = 1'b1;
    conv(10'h1A5, "R7 flag left");
    rd(1'b0, "R3 low left");
    rd(1'b1, "R3 high left");
    rd(1'b1, "R3 high only read");

    rd(1'b0, "R4 low read locks");
    conv(10'h0F0, "R7 flag dropped");
    conv(10'h333, "R7 flag dropped two");
    rd(1'b0, "R4 low while locked");
    rd(1'b1, "R4 high after drop");
    conv(10'h0F0, "R7 flag after unlock");
    rd(1'b0, "R5 low after unlock");
    rd(1'b1, "R5 high after unlock");

    align_left = 1'b0;
    rd(1'b0, "R8 low relaid right");
    rd(1'b1, "R8 high relaid right");
    align_left = 1'b1;
    rd(1'b1, "R8 high relaid left");

    align_left = 1'b0;
    rd_lo_with_conv(10'h155, "R6 low with conv");
    rd(1'b1, "R6 high after same-cycle drop");
    conv(10'h155, "R7 flag retry");
    rd(1'b0, "R6 low after retry");

    rd(1'b1, "R9 setup");
    @(negedge clk);
    held = rd_data;
    conv(10'h2AA, "R7 flag idle");
    repeat (3) @(negedge clk);
    check("R9 hold without read", rd_data, held);

    repeat (2) @(negedge clk);
    if (wd_hit) begin
      tests++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (wd_hit);
    tests++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule